// File: doc/BRIEF.md
# Invert-Flag Bus Encoder and Decoder

This block appends a single invert flag to every data word so that the stored or transmitted form of the word is biased in a chosen direction. The encoder measures how far the candidate word is from a reference word. The candidate is the payload with a cleared flag, and the distance is counted in bits. When that distance is too large, the encoder sends the complemented payload with the flag set. The decoder undoes this by XOR-ing every payload bit with the flag.

Two reference choices are available, and the mode is fixed while the block is held in reset.

- **Transition mode.** The reference is the last encoded word sent. This bounds the bit toggles between successive words.
- **Ones mode.** The reference is a constant all-ones word. No history is needed, and the word is complemented whenever zeros dominate. Memories whose cells read a '1' more cheaply than a '0' benefit from this.

The encoder output is registered, with one cycle of latency. The decoder is purely combinational and sits on a separate port pair, so it can decode words read back from storage.

Top module: `invbit_codec`

## Requirements
- R1: While and right after reset, `enc_vld_o` is 0 and `enc_word_o` is all zeros.
- R2: `enc_vld_o` equals `in_vld_i` of the previous clock cycle.
- R3: The encoded word is N+1 bits with the flag in bit N. The candidate is `{1'b0, in_data_i}`. If the count of ones in the XOR of the candidate with the reference exceeds N/2, the output is `{1'b1, ~in_data_i}`. Otherwise the output is the candidate.
- R4: A distance of exactly N/2 leaves the word uninverted.
- R5: In ones mode (`mode_sel_i`=1 at reset) the reference is all ones. Every valid encoded word then holds at least N/2 ones, counting the flag.
- R6: In transition mode (`mode_sel_i`=0 at reset) the reference is the previously sent encoded word, including its flag; this is all zeros after reset. Two successive valid encoded words then differ in at most N/2 bits.
- R7: The reference history and `enc_word_o` change only on a cycle with `in_vld_i`=1. Idle cycles leave both unchanged.
- R8: `dec_data_o` equals `rx_word_i[N-1:0]` XOR-ed bitwise with `rx_word_i[N]`, and `dec_vld_o` equals `rx_vld_i`, in the same cycle.
- R9: The mode is captured only while `rst` is high. Changing `mode_sel_i` after reset has no effect until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also captures the mode |
| mode_sel_i | input | 1 | Reference mode: 0 transition, 1 ones |
| in_vld_i | input | 1 | Input word valid |
| in_data_i | input | N | Input payload |
| enc_vld_o | output | 1 | Encoded word valid |
| enc_word_o | output | N+1 | Encoded word, flag in bit N |
| rx_vld_i | input | 1 | Received encoded word valid |
| rx_word_i | input | N+1 | Received encoded word |
| dec_vld_o | output | 1 | Decoded word valid |
| dec_data_o | output | N | Decoded payload |

## Verification
Half-ones words such as 0x0000FFFF against a zero history probe the exact tie, which must stay uninverted. A word that is the complement of the history probes full inversion. In ones mode, words with 15 and 16 zeros separate the boundary just below and at the inversion threshold. The all-zeros and all-ones words confirm saturation in each direction.

Long random streams with idle gaps show that history is held across gaps and that toggle and ones bounds hold. The encoder output is looped into the decoder on every cycle, which confirms that both flag values round-trip. Changing the mode input right after a ones-mode reset, then sending 0x0000FFFF, tells the latched mode apart from the live pin.

// File: rtl/invbit_pkg.sv
package invbit_pkg;
  typedef enum logic {
    REF_PREV = 1'b0,
    REF_ONES = 1'b1
  } ref_mode_e;
endpackage

// File: rtl/invbit_distance.sv
module invbit_distance #(
  parameter int W      = 33,
  parameter int THRESH = 16
) (
  input  logic [W-1:0]          cand_i,
  input  logic [W-1:0]          ref_i,
  output logic [$clog2(W+1)-1:0] dist_o,
  output logic                  over_o
);
  localparam int DW = $clog2(W+1);

  function automatic logic [DW-1:0] pop_diff(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [DW-1:0] acc;
    acc = '0;
    for (int i = 0; i < W; i++) acc = acc + DW'(a[i] ^ b[i]);
    return acc;
  endfunction

  assign dist_o = pop_diff(cand_i, ref_i);
  assign over_o = (32'(dist_o) > THRESH);
endmodule

// File: rtl/invbit_encoder.sv
module invbit_encoder
  import invbit_pkg::*;
#(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         mode_sel_i,
  input  logic         in_vld_i,
  input  logic [N-1:0] in_data_i,
  output logic         enc_vld_o,
  output logic [N:0]   enc_word_o
);
  localparam int W  = N + 1;
  localparam int HF = N / 2;
  localparam int DW = $clog2(W+1);

  ref_mode_e        mode_q;
  logic             vld_q;
  logic [N:0]       hist_q;
  logic [N:0]       cand_w;
  logic [N:0]       ref_w;
  logic [N:0]       next_w;
  logic [DW-1:0]    dist_w;
  logic             inv_w;

  assign cand_w = {1'b0, in_data_i};
  assign ref_w  = (mode_q == REF_ONES) ? {W{1'b1}} : hist_q;

  invbit_distance #(.W(W), .THRESH(HF)) dist_i (
    .cand_i (cand_w),
    .ref_i  (ref_w),
    .dist_o (dist_w),
    .over_o (inv_w)
  );

  assign next_w = inv_w ? {1'b1, ~in_data_i} : cand_w;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= ref_mode_e'(mode_sel_i);
      vld_q  <= 1'b0;
      hist_q <= '0;
    end else begin
      vld_q <= in_vld_i;
      if (in_vld_i) hist_q <= next_w;
    end
  end

  assign enc_vld_o  = vld_q;
  assign enc_word_o = hist_q;

  // R2
  vld_latency_chk: assert property (@(posedge clk) disable iff (rst)
    vld_q |-> ($past(in_vld_i) && !$past(rst)));
  // R7
  hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(in_vld_i)) |-> $stable(hist_q));
  // R9
  mode_latched_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable(mode_q));
  // R5
  ones_floor_chk: assert property (@(posedge clk) disable iff (rst)
    (vld_q && mode_q == REF_ONES) |-> ($countones(hist_q) >= HF));
  // R6
  toggle_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (vld_q && mode_q == REF_PREV && !$past(rst)) |-> ($countones(hist_q ^ $past(hist_q)) <= HF));
endmodule

// File: rtl/invbit_decoder.sv
module invbit_decoder #(
  parameter int N = 32
) (
  input  logic         rx_vld_i,
  input  logic [N:0]   rx_word_i,
  output logic         dec_vld_o,
  output logic [N-1:0] dec_data_o
);
  logic flag_w;
  assign flag_w     = rx_word_i[N];
  assign dec_vld_o  = rx_vld_i;
  assign dec_data_o = rx_word_i[N-1:0] ^ {N{flag_w}};
endmodule

// File: rtl/invbit_codec.sv
module invbit_codec #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         mode_sel_i,
  input  logic         in_vld_i,
  input  logic [N-1:0] in_data_i,
  output logic         enc_vld_o,
  output logic [N:0]   enc_word_o,
  input  logic         rx_vld_i,
  input  logic [N:0]   rx_word_i,
  output logic         dec_vld_o,
  output logic [N-1:0] dec_data_o
);
  invbit_encoder #(.N(N)) enc_i (
    .clk        (clk),
    .rst        (rst),
    .mode_sel_i (mode_sel_i),
    .in_vld_i   (in_vld_i),
    .in_data_i  (in_data_i),
    .enc_vld_o  (enc_vld_o),
    .enc_word_o (enc_word_o)
  );

  invbit_decoder #(.N(N)) dec_i (
    .rx_vld_i   (rx_vld_i),
    .rx_word_i  (rx_word_i),
    .dec_vld_o  (dec_vld_o),
    .dec_data_o (dec_data_o)
  );
endmodule

// File: tb/invbit_codec_tb_top.sv
module invbit_codec_tb_top;
  localparam int N      = 32;
  localparam int PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         mode_sel = 1'b0;
  logic         in_vld = 1'b0;
  logic [N-1:0] in_data = '0;
  logic         enc_vld;
  logic [N:0]   enc_word;
  logic         dec_vld;
  logic [N-1:0] dec_data;

  int applied = 0;
  int bad = 0;
  bit ones_mode = 1'b0;
  logic [N:0] hist = '0;
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  invbit_codec #(.N(N)) dut_i (
    .clk        (clk),
    .rst        (rst),
    .mode_sel_i (mode_sel),
    .in_vld_i   (in_vld),
    .in_data_i  (in_data),
    .enc_vld_o  (enc_vld),
    .enc_word_o (enc_word),
    .rx_vld_i   (enc_vld),
    .rx_word_i  (enc_word),
    .dec_vld_o  (dec_vld),
    .dec_data_o (dec_data)
  );

  function automatic int ones_in(input logic [N:0] w);
    int c = 0;
    for (int i = 0; i <= N; i++) if (w[i]) c++;
    return c;
  endfunction

  function automatic logic [N:0] expect_word(input logic [N-1:0] d);
    logic [N:0] r;
    int diff;
    r = ones_mode ? {(N+1){1'b1}} : hist;
    diff = ones_in({1'b0, d} ^ r);
    return (diff > N/2) ? {1'b1, ~d} : {1'b0, d};
  endfunction

  task automatic check(input bit ok, input string req, input logic [N:0] act, input logic [N:0] exp);
    applied++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset(input bit m);
    @(negedge clk);
    rst = 1'b1; mode_sel = m; in_vld = 1'b0;
    repeat (2) @(negedge clk);
    check(enc_vld == 1'b0 && enc_word == '0, "R1", {enc_vld, enc_word[N-1:0]}, '0);
    rst = 1'b0;
    ones_mode = m;
    hist = '0;
  endtask

  task automatic step(input logic v, input logic [N-1:0] d, input string req);
    logic [N:0] e;
    @(negedge clk);
    in_vld = v; in_data = d;
    e = expect_word(d);
    @(posedge clk); #1;
    check(enc_vld == v, "R2", (N+1)'(enc_vld), (N+1)'(v));
    if (v) begin
      check(enc_word == e, req, enc_word, e);
      check(dec_vld && dec_data == d, "R8", {dec_vld, dec_data}, {1'b1, d});
      if (ones_mode) check(ones_in(enc_word) >= N/2, "R5", enc_word, e);
      else check(ones_in(enc_word ^ hist) <= N/2, "R6", enc_word, hist);
      hist = e;
    end else begin
      check(enc_word == hist, "R7", enc_word, hist);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
      $finish;
    end
  end

  initial begin
    // transition mode
    do_reset(1'b0);
    step(1'b1, 32'h0000FFFF, "R4");
    step(1'b1, 32'hFFFF0000, "R3");
    step(1'b0, 32'h12345678, "R7");
    step(1'b0, 32'h00000000, "R7");
    step(1'b1, 32'h0000FFFF, "R6");
    for (int i = 0; i < 300; i++) step(($urandom % 4) != 0, $urandom, "R3");
    // ones mode, then the pin is flipped after reset
    do_reset(1'b1);
    mode_sel = 1'b0;
    step(1'b1, 32'h0000FFFF, "R9");
    step(1'b1, 32'h0001FFFF, "R4");
    step(1'b1, 32'h00000000, "R5");
    step(1'b1, 32'hFFFFFFFF, "R5");
    step(1'b0, 32'hDEADBEEF, "R7");
    for (int i = 0; i < 300; i++) step(($urandom % 4) != 0, $urandom, "R3");
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end
endmodule